// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the control-store address for the next clock cycle in a microprogrammed control unit. Each cycle it takes the sequencing fields of the microinstruction now being executed: a 2-bit condition selector, a 2-bit branch kind and a 7-bit target address. It also takes three status inputs and the four opcode bits of the fetched machine instruction. From these it updates a 7-bit control address register. That register is the block's only output, and it serves as the read address of a 128-word control store. A one-entry return register holds the address that follows a subroutine call.

Four branch kinds exist. JUMP and CALL are conditional. RETURN and MAP ignore the condition. A true condition on JUMP loads the target. A true condition on CALL loads the target and also records the fall-through address in the return register. A false condition on either kind falls through to the next sequential address. RETURN resumes at the recorded address. MAP jumps to the first word of the routine for the current opcode. Routines are spaced four words apart, starting at address 0. Reset places the sequencer at address 64, where the instruction-fetch routine begins.

The branch kind acts as the state that selects each transition:
- SEQ_STEP: fall-through for any conditional kind whose condition is false.
- SEQ_GOTO: a taken JUMP.
- SEQ_ENTER: a taken CALL.
- SEQ_LEAVE: RETURN.
- SEQ_DISPATCH: MAP.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the control address becomes 64 (7'b1000000) and the return register becomes 0.
- R2: The condition is picked by `cond_sel`: 2'b00 is always true, 2'b01 is `ind_bit`, 2'b10 is `sign_bit`, 2'b11 is `zero_flag`.
- R3: With `br_kind` = 2'b00 (JUMP) and a true condition, the next control address equals `br_addr`.
- R4: With `br_kind` = 2'b00 or 2'b01 and a false condition, the next control address is the current one plus 1, modulo 128 (127 steps to 0).
- R5: With `br_kind` = 2'b01 (CALL) and a true condition, the next control address equals `br_addr`, and the return register takes the current address plus 1, modulo 128.
- R6: With `br_kind` = 2'b10 (RETURN), the next control address equals the return register, whatever `cond_sel` and the status inputs are.
- R7: With `br_kind` = 2'b11 (MAP), the next control address is {1'b0, `op_bits`, 2'b00}, whatever `cond_sel` and the status inputs are.
- R8: The return register changes only on a taken CALL. JUMP, a not-taken CALL, RETURN and MAP all leave it unchanged.
- R9: Outside reset, the control address is updated on every rising clock edge, using only the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition selector field of the current microinstruction |
| br_kind | input | 2 | Branch kind field (00 JUMP, 01 CALL, 10 RETURN, 11 MAP) |
| br_addr | input | 7 | Target address field |
| ind_bit | input | 1 | Indirect-address status bit |
| sign_bit | input | 1 | Accumulator sign status bit |
| zero_flag | input | 1 | Accumulator-is-zero status flag |
| op_bits | input | 4 | Opcode bits of the fetched instruction |
| car | output | 7 | Control address register, read address of the control store |

## Verification
On every cycle, the assertions check each transition against the inputs of the previous cycle: the jump target, the fall-through increment, call entry, the return value, the map formula and the post-reset address. They also check that the return register holds its value unless a CALL is taken. Only the bench's scenarios can show that the return register stays unchanged across a long run of unrelated branches, or that a call made at address 127 records 0 and a later return lands there. The bench uses directed sequences for these cases and random microinstruction streams for the rest.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned CAR_W      = 7;
    localparam int unsigned OPC_W      = 4;
    localparam int unsigned MAP_SHIFT  = 2;
    localparam int unsigned FETCH_BASE = 64;

    typedef enum logic [1:0] {
        BK_JUMP   = 2'b00,
        BK_CALL   = 2'b01,
        BK_RETURN = 2'b10,
        BK_MAP    = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        CS_ALWAYS   = 2'b00,
        CS_INDIRECT = 2'b01,
        CS_SIGN     = 2'b10,
        CS_ZERO     = 2'b11
    } cond_sel_e;

    typedef enum logic [2:0] {
        SEQ_STEP,
        SEQ_GOTO,
        SEQ_ENTER,
        SEQ_LEAVE,
        SEQ_DISPATCH
    } seq_move_e;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       ind_bit,
    input  logic       sign_bit,
    input  logic       zero_flag,
    output logic       cond_true
);
    cond_sel_e sel_e;

    always_comb begin
        sel_e = cond_sel_e'(sel);
        unique case (sel_e)
            CS_ALWAYS:   cond_true = 1'b1;
            CS_INDIRECT: cond_true = ind_bit;
            CS_SIGN:     cond_true = sign_bit;
            CS_ZERO:     cond_true = zero_flag;
            default:     cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int unsigned AW    = CAR_W,
    parameter int unsigned OW    = OPC_W,
    parameter int unsigned SHIFT = MAP_SHIFT
) (
    input  logic [1:0]    kind,
    input  logic          cond_true,
    input  logic [AW-1:0] target,
    input  logic [OW-1:0] opcode,
    input  logic [AW-1:0] cur_car,
    input  logic [AW-1:0] cur_ret,
    output logic [AW-1:0] nxt_car,
    output logic          ret_load,
    output logic [AW-1:0] ret_val,
    output seq_move_e     move
);
    localparam int unsigned PAD = AW - OW - SHIFT;

    logic [AW-1:0] inc_addr;
    logic [AW-1:0] map_addr;
    br_kind_e      kind_e;

    assign inc_addr = cur_car + AW'(1);

    generate
        if (PAD > 0) begin : g_pad
            assign map_addr = {{PAD{1'b0}}, opcode, {SHIFT{1'b0}}};
        end else begin : g_nopad
            assign map_addr = {opcode, {SHIFT{1'b0}}};
        end
    endgenerate

    always_comb begin
        kind_e = br_kind_e'(kind);
        unique case (kind_e)
            BK_JUMP:   move = cond_true ? SEQ_GOTO  : SEQ_STEP;
            BK_CALL:   move = cond_true ? SEQ_ENTER : SEQ_STEP;
            BK_RETURN: move = SEQ_LEAVE;
            BK_MAP:    move = SEQ_DISPATCH;
            default:   move = SEQ_STEP;
        endcase
    end

    always_comb begin
        ret_val  = inc_addr;
        ret_load = 1'b0;
        unique case (move)
            SEQ_STEP:     nxt_car = inc_addr;
            SEQ_GOTO:     nxt_car = target;
            SEQ_ENTER: begin
                nxt_car  = target;
                ret_load = 1'b1;
            end
            SEQ_LEAVE:    nxt_car = cur_ret;
            SEQ_DISPATCH: nxt_car = map_addr;
            default:      nxt_car = inc_addr;
        endcase
    end
endmodule

// File: rtl/useq_regs.sv
module useq_regs
    import useq_pkg::*;
#(
    parameter int unsigned AW        = CAR_W,
    parameter int unsigned RESET_CAR = FETCH_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] nxt_car,
    input  logic          ret_load,
    input  logic [AW-1:0] ret_val,
    output logic [AW-1:0] car_q,
    output logic [AW-1:0] ret_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= AW'(RESET_CAR);
            ret_q <= '0;
        end else begin
            car_q <= nxt_car;
            if (ret_load) begin
                ret_q <= ret_val;
            end
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int unsigned AW        = CAR_W,
    parameter int unsigned OW        = OPC_W,
    parameter int unsigned SHIFT     = MAP_SHIFT,
    parameter int unsigned RESET_CAR = FETCH_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cond_sel,
    input  logic [1:0]    br_kind,
    input  logic [AW-1:0] br_addr,
    input  logic          ind_bit,
    input  logic          sign_bit,
    input  logic          zero_flag,
    input  logic [OW-1:0] op_bits,
    output logic [AW-1:0] car
);
    logic          cond_true;
    logic [AW-1:0] nxt_car;
    logic          ret_load;
    logic [AW-1:0] ret_val;
    logic [AW-1:0] car_q;
    logic [AW-1:0] ret_q;
    seq_move_e     move;

    useq_cond_mux u_cond (
        .sel       (cond_sel),
        .ind_bit   (ind_bit),
        .sign_bit  (sign_bit),
        .zero_flag (zero_flag),
        .cond_true (cond_true)
    );

    useq_next_addr #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_next (
        .kind      (br_kind),
        .cond_true (cond_true),
        .target    (br_addr),
        .opcode    (op_bits),
        .cur_car   (car_q),
        .cur_ret   (ret_q),
        .nxt_car   (nxt_car),
        .ret_load  (ret_load),
        .ret_val   (ret_val),
        .move      (move)
    );

    useq_regs #(.AW(AW), .RESET_CAR(RESET_CAR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .nxt_car  (nxt_car),
        .ret_load (ret_load),
        .ret_val  (ret_val),
        .car_q    (car_q),
        .ret_q    (ret_q)
    );

    assign car = car_q;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
    parameter int unsigned AW        = 7,
    parameter int unsigned OW        = 4,
    parameter int unsigned SHIFT     = 2,
    parameter int unsigned RESET_CAR = 64
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cond_sel,
    input logic [1:0]    br_kind,
    input logic [AW-1:0] br_addr,
    input logic          ind_bit,
    input logic          sign_bit,
    input logic          zero_flag,
    input logic [OW-1:0] op_bits,
    input logic [AW-1:0] car,
    input logic [AW-1:0] ret_q
);
    logic cnd;
    assign cnd = (cond_sel == 2'b00) ? 1'b1 :
                 (cond_sel == 2'b01) ? ind_bit :
                 (cond_sel == 2'b10) ? sign_bit : zero_flag;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (car == AW'(RESET_CAR)) && (ret_q == '0));

    // R3
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && cnd) |=> car == $past(br_addr));

    // R4
    fall_through_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind[1] == 1'b0 && !cnd) |=> car == AW'($past(car) + 1'b1));

    // R5
    call_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && cnd) |=>
            (car == $past(br_addr)) && (ret_q == AW'($past(car) + 1'b1)));

    // R6
    return_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10) |=> car == $past(ret_q));

    // R7
    map_chk: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11) |=> car == AW'({$past(op_bits), {SHIFT{1'b0}}}));

    // R8
    ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(br_kind == 2'b01 && cnd) |=> $stable(ret_q));
endmodule

bind useq_sequencer useq_sequencer_chk #(
    .AW(AW), .OW(OW), .SHIFT(SHIFT), .RESET_CAR(RESET_CAR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cond_sel  (cond_sel),
    .br_kind   (br_kind),
    .br_addr   (br_addr),
    .ind_bit   (ind_bit),
    .sign_bit  (sign_bit),
    .zero_flag (zero_flag),
    .op_bits   (op_bits),
    .car       (car),
    .ret_q     (ret_q)
);

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = '0;
    logic [1:0] br_kind = '0;
    logic [6:0] br_addr = '0;
    logic       ind_bit = 1'b0;
    logic       sign_bit = 1'b0;
    logic       zero_flag = 1'b0;
    logic [3:0] op_bits = '0;
    logic [6:0] car;

    int n_vec  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [6:0] m_car = 7'd64;
    logic [6:0] m_ret = 7'd0;

    always #2.5 clk = ~clk;

    useq_sequencer dut (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
        .br_addr(br_addr), .ind_bit(ind_bit), .sign_bit(sign_bit),
        .zero_flag(zero_flag), .op_bits(op_bits), .car(car)
    );

    function automatic logic pick_cond(input logic [1:0] cd, input logic i,
                                       input logic s, input logic z);
        case (cd)
            2'b00:   return 1'b1;
            2'b01:   return i;
            2'b10:   return s;
            default: return z;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] br, input logic c);
        case (br)
            2'b00:   return c ? "R2/R3" : "R2/R4";
            2'b01:   return c ? "R2/R5" : "R2/R4";
            2'b10:   return "R6/R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] act,
                         input logic [6:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: car actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] cd, input logic [1:0] br,
                        input logic [6:0] ad, input logic i, input logic s,
                        input logic z, input logic [3:0] op);
        logic c;
        logic [6:0] exp;
        c = pick_cond(cd, i, s, z);
        cond_sel = cd; br_kind = br; br_addr = ad;
        ind_bit = i; sign_bit = s; zero_flag = z; op_bits = op;
        case (br)
            2'b00: exp = c ? ad : m_car + 7'd1;
            2'b01: exp = c ? ad : m_car + 7'd1;
            2'b10: exp = m_ret;
            default: exp = {1'b0, op, 2'b00};
        endcase
        if (br == 2'b01 && c) m_ret = m_car + 7'd1;
        @(posedge clk);
        @(negedge clk);
        check(req_of(br, c), car, exp);
        m_car = exp;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", car, 7'd64);
        rst = 1'b0;
        m_car = 7'd64; m_ret = 7'd0;

        // R6: return straight after reset yields cleared return register (R1)
        step(2'b11, 2'b10, 7'd99, 1'b1, 1'b1, 1'b1, 4'hF);
        // R2 each condition, taken and not
        step(2'b01, 2'b00, 7'd20, 1'b0, 1'b1, 1'b1, 4'h0);
        step(2'b01, 2'b00, 7'd30, 1'b1, 1'b0, 1'b0, 4'h0);
        step(2'b10, 2'b00, 7'd40, 1'b1, 1'b0, 1'b1, 4'h0);
        step(2'b10, 2'b00, 7'd50, 1'b0, 1'b1, 1'b0, 4'h0);
        step(2'b11, 2'b00, 7'd60, 1'b1, 1'b1, 1'b0, 4'h0);
        step(2'b11, 2'b00, 7'd70, 1'b0, 1'b0, 1'b1, 4'h0);
        // R4: wrap 127 -> 0
        step(2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0);
        step(2'b01, 2'b00, 7'd5, 1'b0, 1'b0, 1'b0, 4'h0);
        // R5: call at 127 records 0
        step(2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0);
        step(2'b00, 2'b01, 7'd67, 1'b0, 1'b0, 1'b0, 4'h0);
        // R8: unrelated branches leave return register alone
        step(2'b01, 2'b01, 7'd10, 1'b0, 1'b0, 1'b0, 4'h0);
        step(2'b00, 2'b00, 7'd33, 1'b0, 1'b0, 1'b0, 4'h0);
        step(2'b10, 2'b11, 7'd1, 1'b0, 1'b1, 1'b0, 4'h9);
        step(2'b10, 2'b10, 7'd1, 1'b0, 1'b0, 1'b0, 4'h2);
        // R7: map extremes, CD ignored
        step(2'b01, 2'b11, 7'd100, 1'b0, 1'b0, 1'b0, 4'hF);
        step(2'b11, 2'b11, 7'd100, 1'b1, 1'b1, 1'b1, 4'h0);

        // R9: random streams, model updated every cycle
        for (int k = 0; k < 3000; k++) begin
            step(2'($urandom), 2'($urandom), 7'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 4'($urandom));
        end

        // R1: reset mid-run
        step(2'b00, 2'b01, 7'd90, 1'b0, 1'b0, 1'b0, 4'h0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", car, 7'd64);
        rst = 1'b0;
        m_car = 7'd64; m_ret = 7'd0;
        step(2'b00, 2'b10, 7'd3, 1'b0, 1'b0, 1'b0, 4'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule